// File: doc/BRIEF.md
# Keyed Power-Domain Sequencer

This block is a register-mapped controller for eight power domains. Software first loads a bitmask of domains into one of two request registers, one for switching domains on and one for switching them off. The request is committed only when an exact three-word key is written to a single trigger register. There is one key for power-on and a different key for power-off. A key sequence that is broken part way is rejected and flagged as a software failure.

Once a request is committed, the block walks the requested domains one at a time, from the lowest bit upward. Each domain takes a fixed number of clock cycles, and a counter stands in for the real power switch. When a domain finishes, its bit in the current-mode register is updated and a per-domain event bit is raised. When the last domain finishes, a sequence-done flag is raised. Status flags are write-one-to-clear, and each can be masked individually. One interrupt line reports any flag that is not masked.

Two domains, 0 and 1, are permanently powered. A power-off request never clears them. The slave port is a simple 32-bit bus with a setup phase and an access phase. Read data is combinational from the address.

Top module: `pwr_key_seq`

## Requirements
- R1: After reset the current-mode register (0x80) reads 0xFF, the interrupt mask (0x48) reads 0x1FF, the on/off request registers (0x0C, 0x10) read 0, interrupt status (0x8C) and event status (0x88) read 0, and irq_o is low.
- R2: The on-request (0x0C, 8 bits), off-request (0x10, 8 bits) and interrupt mask (0x48, 9 bits) registers read back what was written. The trigger register (0x44) and unmapped addresses read 0.
- R3: Writing the 32-bit values 0xFF, 0x05, 0x50 to 0x44 in that order commits a power-on of the domains set in the on-request register. Each such domain's bit in 0x80 becomes 1.
- R4: Writing 0xFF, 0x0A, 0xA0 to 0x44 in that order commits a power-off of the domains set in the off-request register. Each such domain's bit in 0x80 becomes 0, except bits 0 and 1, which stay 1 at all times.
- R5: The requested domains are handled one at a time, lowest index first, and each takes 16 cycles. The n-th handled domain changes its bit in 0x80 on the 16·n-th rising edge after the edge that accepts the final key word, and no two bits of 0x80 change on the same edge.
- R6: Status bit 0 (sequence done) is set on the edge where the last requested domain finishes. If the request mask is empty, it is set on the commit edge. Event status bit i is set when domain i finishes.
- R7: A trigger write that breaks the key order returns the detector to idle and leaves 0x80 unchanged. A wrong second word sets status bits 2 and 3. A wrong third word after 0x05 sets bit 2, and after 0x0A sets bit 3. A non-0xFF write while idle has no effect.
- R8: A key sequence that completes while domains are still being switched is ignored. A power-on key sets status bit 2 and a power-off key sets bit 3.
- R9: Writing ones to 0x8C or 0x88 clears those bits. A flag being set on the same edge wins over the clear.
- R10: irq_o is high exactly when some status bit is 1 and the matching interrupt mask bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Slave select |
| bus_en | input | 1 | Access phase enable |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data of the addressed register |
| irq_o | output | 1 | Interrupt line |

## Verification
The bench targets key sequences broken at each of the three positions, a stray key word while idle, a complete key arriving while a sequence is running, and an empty request mask. A design that commits on a partial key, or flags the wrong failure bit, shows up immediately in the status register. A design that clears always-on domains, handles domains out of order or is one cycle off in the 16-cycle step diverges from the per-clock model in the current-mode register. A design that lets a clear override a simultaneous set, or that ignores the mask, disagrees on the interrupt line.

// File: rtl/pks_pkg.sv
package pks_pkg;
  // register offsets (software decodes these)
  localparam int A_ON_REQ  = 'h0C;
  localparam int A_OFF_REQ = 'h10;
  localparam int A_TRIG    = 'h44;
  localparam int A_IMASK   = 'h48;
  localparam int A_MODE    = 'h80;
  localparam int A_EVENT   = 'h88;
  localparam int A_STATUS  = 'h8C;

  // key words
  localparam int K_ARM  = 'hFF;
  localparam int K_ON1  = 'h05;
  localparam int K_ON2  = 'h50;
  localparam int K_OFF1 = 'h0A;
  localparam int K_OFF2 = 'hA0;

  // status layout
  localparam int ST_W       = 9;
  localparam int ST_DONE    = 0;
  localparam int ST_SWF_ON  = 2;
  localparam int ST_SWF_OFF = 3;

  typedef enum logic [1:0] {
    KEY_IDLE  = 2'd0,
    KEY_ARMED = 2'd1,
    KEY_ON    = 2'd2,
    KEY_OFF   = 2'd3
  } key_state_e;
endpackage

// File: rtl/pks_key_fsm.sv
module pks_key_fsm
  import pks_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trig_wr,
  input  logic [DATA_W-1:0] trig_data,
  output logic              commit_on,
  output logic              commit_off,
  output logic              fail_on,
  output logic              fail_off
);
  key_state_e state_q, state_d;

  always_comb begin
    state_d    = state_q;
    commit_on  = 1'b0;
    commit_off = 1'b0;
    fail_on    = 1'b0;
    fail_off   = 1'b0;
    if (trig_wr) begin
      case (state_q)
        KEY_IDLE: begin
          if (trig_data == DATA_W'(K_ARM)) state_d = KEY_ARMED;
        end
        KEY_ARMED: begin
          if (trig_data == DATA_W'(K_ON1))       state_d = KEY_ON;
          else if (trig_data == DATA_W'(K_OFF1)) state_d = KEY_OFF;
          else begin
            state_d  = KEY_IDLE;
            fail_on  = 1'b1;
            fail_off = 1'b1;
          end
        end
        KEY_ON: begin
          state_d = KEY_IDLE;
          if (trig_data == DATA_W'(K_ON2)) commit_on = 1'b1;
          else                             fail_on   = 1'b1;
        end
        KEY_OFF: begin
          state_d = KEY_IDLE;
          if (trig_data == DATA_W'(K_OFF2)) commit_off = 1'b1;
          else                              fail_off   = 1'b1;
        end
        default: state_d = KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       state_q <= KEY_IDLE;
    else if (trig_wr) state_q <= state_d;
  end
endmodule

// File: rtl/pks_switch_seq.sv
module pks_switch_seq #(
  parameter int N_DOM  = 8,
  parameter int SW_CYC = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             dir,
  input  logic [N_DOM-1:0] req_mask,
  output logic             busy,
  output logic [N_DOM-1:0] mode,
  output logic [N_DOM-1:0] dom_done,
  output logic             seq_done
);
  localparam int CNT_W = (SW_CYC > 1) ? $clog2(SW_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(SW_CYC - 1);

  logic [N_DOM-1:0] pend_q, pend_d, mode_q, mode_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             busy_q, busy_d, dir_q, dir_d;
  logic [N_DOM-1:0] cur_oh, rest;
  logic             last_tick;

  assign cur_oh    = pend_q & (~pend_q + N_DOM'(1));
  assign rest      = pend_q & ~cur_oh;
  assign last_tick = busy_q && (cnt_q == CNT_LAST);

  always_comb begin
    pend_d   = pend_q;
    mode_d   = mode_q;
    cnt_d    = cnt_q;
    busy_d   = busy_q;
    dir_d    = dir_q;
    dom_done = '0;
    seq_done = 1'b0;
    if (start) begin
      pend_d   = req_mask;
      dir_d    = dir;
      cnt_d    = '0;
      busy_d   = |req_mask;
      seq_done = ~|req_mask;
    end else if (busy_q) begin
      if (last_tick) begin
        dom_done = cur_oh;
        pend_d   = rest;
        mode_d   = dir_q ? (mode_q | cur_oh) : (mode_q & ~cur_oh);
        cnt_d    = '0;
        if (rest == '0) begin
          busy_d   = 1'b0;
          seq_done = 1'b1;
        end
      end else begin
        cnt_d = cnt_q + CNT_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      mode_q <= '1;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      dir_q  <= 1'b0;
    end else begin
      pend_q <= pend_d;
      mode_q <= mode_d;
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      dir_q  <= dir_d;
    end
  end

  assign busy = busy_q;
  assign mode = mode_q;
endmodule

// File: rtl/pks_irq_ctl.sv
module pks_irq_ctl #(
  parameter int N_DOM = 8,
  parameter int SW    = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    set_sts,
  input  logic [N_DOM-1:0] set_ev,
  input  logic             wr_sts,
  input  logic             wr_ev,
  input  logic             wr_imask,
  input  logic [SW-1:0]    wdata_sw,
  input  logic [N_DOM-1:0] wdata_ev,
  output logic [SW-1:0]    sts,
  output logic [N_DOM-1:0] ev,
  output logic [SW-1:0]    imask,
  output logic             irq
);
  logic [SW-1:0]    sts_q, sts_d, imask_q;
  logic [N_DOM-1:0] ev_q, ev_d;

  always_comb begin
    sts_d = wr_sts ? (sts_q & ~wdata_sw) : sts_q;
    sts_d = sts_d | set_sts;
    ev_d  = wr_ev ? (ev_q & ~wdata_ev) : ev_q;
    ev_d  = ev_d | set_ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sts_q <= '0;
      ev_q  <= '0;
    end else begin
      sts_q <= sts_d;
      ev_q  <= ev_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        imask_q <= '1;
    else if (wr_imask) imask_q <= wdata_sw;
  end

  assign sts   = sts_q;
  assign ev    = ev_q;
  assign imask = imask_q;
  assign irq   = |(sts_q & ~imask_q);
endmodule

// File: rtl/pwr_key_seq.sv
module pwr_key_seq
  import pks_pkg::*;
#(
  parameter int               N_DOM    = 8,
  parameter int               SW_CYC   = 16,
  parameter int               ADDR_W   = 8,
  parameter int               DATA_W   = 32,
  parameter logic [N_DOM-1:0] AON_MASK = N_DOM'(3)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_en,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o
);
  // reset: asserted asynchronously, released after two clock edges
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // write decode
  logic wr_en, wr_on, wr_off, trig_wr, wr_imask, wr_ev, wr_sts;
  assign wr_en    = bus_sel & bus_en & bus_wr;
  assign wr_on    = wr_en && (bus_addr == ADDR_W'(A_ON_REQ));
  assign wr_off   = wr_en && (bus_addr == ADDR_W'(A_OFF_REQ));
  assign trig_wr  = wr_en && (bus_addr == ADDR_W'(A_TRIG));
  assign wr_imask = wr_en && (bus_addr == ADDR_W'(A_IMASK));
  assign wr_ev    = wr_en && (bus_addr == ADDR_W'(A_EVENT));
  assign wr_sts   = wr_en && (bus_addr == ADDR_W'(A_STATUS));

  // request registers
  logic [N_DOM-1:0] on_req_q, off_req_q;
  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      on_req_q  <= '0;
      off_req_q <= '0;
    end else begin
      if (wr_on)  on_req_q  <= bus_wdata[N_DOM-1:0];
      if (wr_off) off_req_q <= bus_wdata[N_DOM-1:0];
    end
  end

  // key detector
  logic key_commit_on, key_commit_off, key_fail_on, key_fail_off;
  pks_key_fsm #(.DATA_W(DATA_W)) u_key (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .trig_wr    (trig_wr),
    .trig_data  (bus_wdata),
    .commit_on  (key_commit_on),
    .commit_off (key_commit_off),
    .fail_on    (key_fail_on),
    .fail_off   (key_fail_off)
  );

  // sequencer
  logic             seq_busy, seq_start, seq_dir, seq_done;
  logic [N_DOM-1:0] seq_req, cur_mode, dom_done;

  assign seq_start = (key_commit_on | key_commit_off) & ~seq_busy;
  assign seq_dir   = key_commit_on;
  assign seq_req   = key_commit_on ? on_req_q : (off_req_q & ~AON_MASK);

  pks_switch_seq #(.N_DOM(N_DOM), .SW_CYC(SW_CYC)) u_seq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (seq_start),
    .dir      (seq_dir),
    .req_mask (seq_req),
    .busy     (seq_busy),
    .mode     (cur_mode),
    .dom_done (dom_done),
    .seq_done (seq_done)
  );

  // status and interrupt
  logic [ST_W-1:0]  sts_set, sts_q, imask_q;
  logic [N_DOM-1:0] ev_q;

  always_comb begin
    sts_set             = '0;
    sts_set[ST_DONE]    = seq_done;
    sts_set[ST_SWF_ON]  = key_fail_on  | (key_commit_on  & seq_busy);
    sts_set[ST_SWF_OFF] = key_fail_off | (key_commit_off & seq_busy);
  end

  pks_irq_ctl #(.N_DOM(N_DOM), .SW(ST_W)) u_irq (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .set_sts  (sts_set),
    .set_ev   (dom_done),
    .wr_sts   (wr_sts),
    .wr_ev    (wr_ev),
    .wr_imask (wr_imask),
    .wdata_sw (bus_wdata[ST_W-1:0]),
    .wdata_ev (bus_wdata[N_DOM-1:0]),
    .sts      (sts_q),
    .ev       (ev_q),
    .imask    (imask_q),
    .irq      (irq_o)
  );

  // read mux
  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(A_ON_REQ):  bus_rdata[N_DOM-1:0] = on_req_q;
      ADDR_W'(A_OFF_REQ): bus_rdata[N_DOM-1:0] = off_req_q;
      ADDR_W'(A_IMASK):   bus_rdata[ST_W-1:0]  = imask_q;
      ADDR_W'(A_MODE):    bus_rdata[N_DOM-1:0] = cur_mode;
      ADDR_W'(A_EVENT):   bus_rdata[N_DOM-1:0] = ev_q;
      ADDR_W'(A_STATUS):  bus_rdata[ST_W-1:0]  = sts_q;
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/pks_checker.sv
module pks_checker
  import pks_pkg::*;
#(
  parameter int               N_DOM    = 8,
  parameter int               DATA_W   = 32,
  parameter logic [N_DOM-1:0] AON_MASK = N_DOM'(3)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              trig_wr,
  input logic [DATA_W-1:0] trig_data,
  input logic [N_DOM-1:0]  mode,
  input logic [ST_W-1:0]   sts,
  input logic [ST_W-1:0]   imask,
  input logic              irq
);
  // R4: always-on domains never drop
  assert_aon_kept_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (mode & AON_MASK) == AON_MASK);

  // R5: one domain changes per edge at most
  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode ^ $past(mode)) <= 1);

  // R3: switching starts only right after a final key word
  assert_start_by_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> ($past(trig_wr) &&
      ($past(trig_data) == DATA_W'(K_ON2) || $past(trig_data) == DATA_W'(K_OFF2))));

  // R6: end of switching leaves sequence-done set
  assert_done_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> sts[ST_DONE]);

  // R10: fully masked means quiet line
  assert_masked_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (imask == '1) |-> !irq);
endmodule

bind pwr_key_seq pks_checker #(
  .N_DOM    (N_DOM),
  .DATA_W   (DATA_W),
  .AON_MASK (AON_MASK)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_int_n),
  .busy      (seq_busy),
  .trig_wr   (trig_wr),
  .trig_data (bus_wdata),
  .mode      (cur_mode),
  .sts       (sts_q),
  .imask     (imask_q),
  .irq       (irq_o)
);

// File: tb/pwr_key_seq_test.sv
module pwr_key_seq_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sel, en, wr;
  logic [7:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic        irq;

  always #4 clk = ~clk;

  pwr_key_seq uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(sel), .bus_en(en), .bus_wr(wr),
    .bus_addr(addr), .bus_wdata(wdata), .bus_rdata(rdata), .irq_o(irq)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [7:0] m_mode, m_ev, m_on, m_off;
  logic [8:0] m_sts, m_imask;
  int         m_key;
  int         m_q[$];
  int         m_left;
  bit         m_dir;

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    case (a)
      8'h0C: return {24'h0, m_on};
      8'h10: return {24'h0, m_off};
      8'h48: return {23'h0, m_imask};
      8'h80: return {24'h0, m_mode};
      8'h88: return {24'h0, m_ev};
      8'h8C: return {23'h0, m_sts};
      default: return 32'h0;
    endcase
  endfunction

  function automatic string tag_for(input logic [7:0] a);
    case (a)
      8'h80: return "R5 mode";
      8'h88: return "R6 event";
      8'h8C: return "R9 status";
      default: return "R2 reg";
    endcase
  endfunction

  always @(posedge clk) begin : model
    bit         busy0;
    logic [8:0] sset;
    logic [7:0] eset;
    logic [7:0] msk;
    int         idx;
    if (!rst_n) begin
      m_mode = 8'hFF; m_ev = 0; m_on = 0; m_off = 0;
      m_sts = 0; m_imask = 9'h1FF; m_key = 0; m_q.delete(); m_left = 0; m_dir = 0;
    end else begin
      busy0 = (m_q.size() != 0);
      sset = 0; eset = 0;
      if (busy0) begin
        m_left--;
        if (m_left == 0) begin
          idx = m_q.pop_front();
          m_mode[idx] = m_dir;
          eset[idx] = 1'b1;
          if (m_q.size() == 0) sset[0] = 1'b1;
          else m_left = 16;
        end
      end
      if (sel && en && wr) begin
        case (addr)
          8'h44: begin
            case (m_key)
              0: if (wdata == 32'hFF) m_key = 1;
              1: begin
                if (wdata == 32'h05) m_key = 2;
                else if (wdata == 32'h0A) m_key = 3;
                else begin sset[2] = 1; sset[3] = 1; m_key = 0; end
              end
              default: begin
                if (m_key == 2 && wdata != 32'h50) sset[2] = 1;
                else if (m_key == 3 && wdata != 32'hA0) sset[3] = 1;
                else if (busy0) begin
                  if (m_key == 2) sset[2] = 1; else sset[3] = 1;
                end else begin
                  m_dir = (m_key == 2);
                  msk = m_dir ? m_on : (m_off & 8'hFC);
                  for (int i = 0; i < 8; i++) if (msk[i]) m_q.push_back(i);
                  if (m_q.size() == 0) sset[0] = 1;
                  else m_left = 16;
                end
                m_key = 0;
              end
            endcase
          end
          8'h0C: m_on = wdata[7:0];
          8'h10: m_off = wdata[7:0];
          8'h48: m_imask = wdata[8:0];
          8'h88: m_ev = m_ev & ~wdata[7:0];
          8'h8C: m_sts = m_sts & ~wdata[8:0];
          default: ;
        endcase
      end
      m_sts = m_sts | sset;
      m_ev  = m_ev | eset;
    end
  end

  // per-clock comparison, sampled away from the edge
  always @(posedge clk) begin
    #2;
    if (rst_n && !finished) begin
      check("R10 irq", {31'h0, irq}, {31'h0, |(m_sts & ~m_imask)});
      check(tag_for(addr), rdata, exp_rd(addr));
    end
  end

  // ---------------- stimulus ----------------
  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); sel = 1; en = 0; wr = 1; addr = a; wdata = d;
    @(negedge clk); en = 1;
    @(negedge clk); sel = 0; en = 0; wr = 0;
  endtask

  task automatic bus_read(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); addr = a;
    #1 check(tag, rdata, exp);
  endtask

  task automatic key3(input logic [31:0] k1, input logic [31:0] k2, input logic [31:0] k3);
    bus_write(8'h44, k1); bus_write(8'h44, k2); bus_write(8'h44, k3);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel = 0; en = 0; wr = 0; addr = 8'h80; wdata = 0;
    idle(3);
    rst_n = 1;
    idle(4);

    // R1 reset state
    bus_read(8'h80, 32'hFF,  "R1 mode");
    bus_read(8'h48, 32'h1FF, "R1 imask");
    bus_read(8'h0C, 32'h0,   "R1 on req");
    bus_read(8'h8C, 32'h0,   "R1 status");
    bus_read(8'h88, 32'h0,   "R1 event");
    check("R1 irq", {31'h0, irq}, 32'h0);

    // R2 read-back
    bus_write(8'h48, 32'h0);
    bus_read(8'h48, 32'h0, "R2 imask");
    bus_write(8'h0C, 32'h3C);
    bus_read(8'h0C, 32'h3C, "R2 on req");
    bus_write(8'h10, 32'hFF);
    bus_read(8'h10, 32'hFF, "R2 off req");
    bus_read(8'h44, 32'h0, "R2 trig reads 0");
    bus_read(8'h20, 32'h0, "R2 unmapped");

    // R4 / R5 power-off of 0xFC
    key3(32'hFF, 32'h0A, 32'hA0);
    idle(14);
    bus_read(8'h80, 32'hFF, "R5 before first step");
    bus_read(8'h80, 32'hFB, "R5 bit2 at 16");
    idle(15);
    bus_read(8'h80, 32'hF3, "R5 bit3 at 32");
    idle(80);
    bus_read(8'h80, 32'h03, "R4 off keeps 0,1");
    bus_read(8'h8C, 32'h001, "R6 done");
    bus_read(8'h88, 32'hFC, "R6 events");
    check("R10 irq unmasked", {31'h0, irq}, 32'h1);

    // R9 clears
    bus_write(8'h8C, 32'h1);
    bus_read(8'h8C, 32'h0, "R9 status clear");
    check("R10 irq low", {31'h0, irq}, 32'h0);
    bus_write(8'h88, 32'hFC);
    bus_read(8'h88, 32'h0, "R9 event clear");

    // R3 power-on of 0x3C
    key3(32'hFF, 32'h05, 32'h50);
    idle(80);
    bus_read(8'h80, 32'h3F, "R3 on");
    bus_write(8'h8C, 32'h1FF);
    bus_write(8'h88, 32'hFF);

    // R7 broken keys
    key3(32'hFF, 32'h05, 32'h55);
    bus_read(8'h8C, 32'h004, "R7 bad third on");
    bus_read(8'h80, 32'h3F, "R7 mode kept");
    bus_write(8'h8C, 32'h1FF);
    key3(32'hFF, 32'h0A, 32'h00);
    bus_read(8'h8C, 32'h008, "R7 bad third off");
    bus_write(8'h8C, 32'h1FF);
    bus_write(8'h44, 32'hFF); bus_write(8'h44, 32'h33);
    bus_read(8'h8C, 32'h00C, "R7 bad second");
    bus_write(8'h8C, 32'h1FF);
    bus_write(8'h44, 32'h50);
    bus_read(8'h8C, 32'h0, "R7 idle stray");
    bus_read(8'h80, 32'h3F, "R7 idle mode kept");

    // R8 commit while busy
    bus_write(8'h10, 32'h30);
    key3(32'hFF, 32'h0A, 32'hA0);
    key3(32'hFF, 32'h05, 32'h50);
    idle(40);
    bus_read(8'h8C, 32'h005, "R8 busy fail");
    bus_read(8'h80, 32'h0F, "R8 on ignored");
    bus_write(8'h8C, 32'h1FF);
    bus_write(8'h88, 32'hFF);

    // R6 empty mask
    bus_write(8'h0C, 32'h0);
    key3(32'hFF, 32'h05, 32'h50);
    bus_read(8'h8C, 32'h001, "R6 empty done");
    bus_read(8'h80, 32'h0F, "R6 empty mode");

    // R10 masking
    bus_write(8'h48, 32'h1FF);
    check("R10 masked", {31'h0, irq}, 32'h0);
    bus_write(8'h48, 32'h1FE);
    check("R10 enabled", {31'h0, irq}, 32'h1);

    idle(3);
    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule